// File: doc/BRIEF.md
# Neutral-Point Balance Trim Controller

This block watches the lower DC-link capacitor of a three-level converter and decides a small duty-ratio correction that pulls the neutral point back toward half of the bus voltage. Once per switching period a sample strobe delivers the capacitor voltage and the bus voltage. The block forms the error between the capacitor voltage and half the bus. It then applies a bang-bang rule instead of a proportional-integral loop.

A dead-zone comparator decides whether a correction is applied at all. While the error magnitude stays within the dead band, both trim outputs are zero. Outside the dead band a fixed-magnitude trim is produced. Its polarity comes from a sign-hysteresis stage that reverses the polarity once each time the error pushes out past a wider band. The stage re-arms only after the error comes back inside that band. The polarity is remembered across idle spells, so a new activation starts with the polarity used last. The primary-side trim and the secondary-side trim are always equal in magnitude and opposite in sign.

Voltages are signed 16-bit values in 0.1 V steps. The two band thresholds are run-time inputs, nominally 10 (1 V) and 100 (10 V). The trim is a signed value in 1/1024 of full duty, nominally 31 (about 0.03).

Top module: `npb_trim_ctrl`

## Requirements
- R1: The error is the capacitor voltage minus the bus voltage halved with rounding toward minus infinity; an odd bus value of 4001 gives a midpoint of 2000 and a bus of -4001 gives -2001.
- R2: On a strobe, the enable output becomes 1 if the error magnitude is strictly greater than the dead-band threshold and 0 otherwise; while enable is 0 both trims are zero.
- R3: While enable is 1 the primary trim equals +TRIM_MAG when the held polarity is positive and -TRIM_MAG when it is negative.
- R4: On a strobe with enable 1 and the error magnitude strictly above the hysteresis threshold, the polarity reverses if the reversal is armed, and the reversal is then disarmed; a strobe whose magnitude is at or below the hysteresis threshold re-arms it.
- R5: After reset, enable is 0, both trims are 0, the polarity is positive and the reversal is armed.
- R6: The polarity is kept while enable is 0, so the next activation resumes with the last polarity used.
- R7: The secondary trim is always the two's-complement negation of the primary trim.
- R8: The outputs and the internal polarity state change only on cycles where the strobe is high, and hold otherwise.
- R9: Threshold inputs take effect on the first strobe that sees the new value, with no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_vld | input | 1 | One-cycle strobe marking a new voltage sample |
| cap_volt | input | VOLT_W | Lower capacitor voltage, signed, 0.1 V units |
| bus_volt | input | VOLT_W | Full DC-bus voltage, signed, 0.1 V units |
| dz_thr | input | VOLT_W | Dead-band half-width, unsigned, 0.1 V units |
| hys_thr | input | VOLT_W | Hysteresis half-width, unsigned, 0.1 V units |
| trim_pri | output | TRIM_W | Signed duty trim for the primary bridge |
| trim_sec | output | TRIM_W | Signed duty trim for the secondary bridge |
| trim_en | output | 1 | High while a trim is being applied |

## Verification
The assertions check, on every cycle, the output relations: secondary trim as the negation of the primary trim, zero trim while disabled, a trim magnitude of exactly TRIM_MAG while enabled, and outputs that hold between strobes. Whether the polarity reverses once per outward excursion, re-arms at the right moment and survives idle spells depends on the history of the error. So do the dead-band and hysteresis comparisons at their exact boundary values and the rounding of odd bus values. Only the bench's ramps, boundary sweeps and long random walks, checked against an arithmetic model, can show these.

// File: rtl/npb_pkg.sv
// Package: shared types for the neutral-point balance trim controller.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package npb_pkg;

    // Result of comparing the error magnitude against the two bands.
    typedef struct packed {
        logic above_dz;   // magnitude strictly greater than dead-band threshold
        logic above_hy;   // magnitude strictly greater than hysteresis threshold
    } band_t;

endpackage

// File: rtl/npb_err_calc.sv
// Module: npb_err_calc
// Forms |cap - floor(bus/2)| combinationally. The result is one bit wider
// than the inputs so that no input combination can overflow.
// Assumes: both voltages are two's-complement values of VOLT_W bits.
module npb_err_calc #(
    parameter int VOLT_W = 16,
    localparam int ERR_W = VOLT_W + 1
) (
    input  logic signed [VOLT_W-1:0] cap_volt,
    input  logic signed [VOLT_W-1:0] bus_volt,
    output logic        [ERR_W-1:0]  err_mag
);
    logic signed [VOLT_W-1:0] mid_volt;
    logic signed [ERR_W-1:0]  err_s;

    // Midpoint and signed error, sign-extended to avoid wrap.
    always_comb begin
        mid_volt = bus_volt >>> 1;
        err_s    = ERR_W'(cap_volt) - ERR_W'(mid_volt);
        err_mag  = err_s[ERR_W-1] ? ERR_W'(-err_s) : ERR_W'(err_s);
    end
endmodule

// File: rtl/npb_band_cmp.sv
// Module: npb_band_cmp
// Compares the error magnitude against the dead-band and hysteresis
// thresholds (both strict greater-than).
// Assumes: thresholds are unsigned; no ordering between them is required.
module npb_band_cmp
    import npb_pkg::*;
#(
    parameter int VOLT_W = 16,
    localparam int ERR_W = VOLT_W + 1
) (
    input  logic [ERR_W-1:0]  err_mag,
    input  logic [VOLT_W-1:0] dz_thr,
    input  logic [VOLT_W-1:0] hys_thr,
    output band_t             band
);
    // Two independent magnitude comparisons.
    always_comb begin
        band.above_dz = err_mag > ERR_W'(dz_thr);
        band.above_hy = err_mag > ERR_W'(hys_thr);
    end
endmodule

// File: rtl/npb_sign_hyst.sv
// Module: npb_sign_hyst
// Holds the trim polarity and the re-arm flag of the sign-hysteresis stage.
// The polarity flips once per outward excursion past the hysteresis band
// while trimming is enabled; it re-arms when the magnitude is back inside.
// Assumes: step is high for one cycle per sample; state moves only then.
module npb_sign_hyst
    import npb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  band_t band,
    output logic  neg_nxt,    // polarity that applies to this sample
    output logic  neg_q       // polarity held since the last sample
);
    logic armed_q;
    logic flip;

    // Reversal condition for the current sample.
    always_comb begin
        flip    = band.above_dz && band.above_hy && armed_q;
        neg_nxt = neg_q ^ flip;
    end

    // Polarity and arm state, advanced only on a sample step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q   <= 1'b0;
            armed_q <= 1'b1;
        end else if (step) begin
            neg_q   <= neg_nxt;
            armed_q <= !band.above_hy;
        end
    end
endmodule

// File: rtl/npb_trim_ctrl.sv
// Module: npb_trim_ctrl (top)
// Dead-zone enable plus sign-hysteresis polarity produce a fixed-size
// duty trim for the primary bridge and its negation for the secondary.
// Outputs are registered and updated only on the sample strobe.
// Assumes: TRIM_MAG fits as a positive value in TRIM_W bits.
module npb_trim_ctrl
    import npb_pkg::*;
#(
    parameter int VOLT_W   = 16,
    parameter int TRIM_W   = 12,
    parameter int TRIM_MAG = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_vld,
    input  logic signed [VOLT_W-1:0] cap_volt,
    input  logic signed [VOLT_W-1:0] bus_volt,
    input  logic        [VOLT_W-1:0] dz_thr,
    input  logic        [VOLT_W-1:0] hys_thr,
    output logic signed [TRIM_W-1:0] trim_pri,
    output logic signed [TRIM_W-1:0] trim_sec,
    output logic                     trim_en
);
    localparam int ERR_W = VOLT_W + 1;
    localparam logic signed [TRIM_W-1:0] MAG_POS = TRIM_W'(TRIM_MAG);
    localparam logic signed [TRIM_W-1:0] MAG_NEG = -MAG_POS;

    logic [ERR_W-1:0] err_mag;
    band_t            band;
    logic             neg_nxt;
    logic             neg_q;
    logic signed [TRIM_W-1:0] trim_nxt;

    npb_err_calc #(.VOLT_W(VOLT_W)) u_err (
        .cap_volt (cap_volt),
        .bus_volt (bus_volt),
        .err_mag  (err_mag)
    );

    npb_band_cmp #(.VOLT_W(VOLT_W)) u_band (
        .err_mag (err_mag),
        .dz_thr  (dz_thr),
        .hys_thr (hys_thr),
        .band    (band)
    );

    npb_sign_hyst u_sign (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (sample_vld),
        .band    (band),
        .neg_nxt (neg_nxt),
        .neg_q   (neg_q)
    );

    // Trim selected by enable and the polarity for this sample.
    always_comb begin
        if (!band.above_dz) trim_nxt = '0;
        else if (neg_nxt)   trim_nxt = MAG_NEG;
        else                trim_nxt = MAG_POS;
    end

    // Output registers, loaded on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_pri <= '0;
            trim_sec <= '0;
            trim_en  <= 1'b0;
        end else if (sample_vld) begin
            trim_pri <= trim_nxt;
            trim_sec <= -trim_nxt;
            trim_en  <= band.above_dz;
        end
    end
endmodule

// File: rtl/npb_trim_ctrl_chk.sv
// Module: npb_trim_ctrl_chk
// Cycle-level properties of the trim outputs, bound to npb_trim_ctrl.
// Assumes: same parameters as the bound instance.
module npb_trim_ctrl_chk #(
    parameter int VOLT_W   = 16,
    parameter int TRIM_W   = 12,
    parameter int TRIM_MAG = 31
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sample_vld,
    input logic signed [TRIM_W-1:0] trim_pri,
    input logic signed [TRIM_W-1:0] trim_sec,
    input logic                     trim_en
);
    localparam logic signed [TRIM_W-1:0] MAG_POS = TRIM_W'(TRIM_MAG);
    localparam logic signed [TRIM_W-1:0] MAG_NEG = -MAG_POS;

    // Secondary always mirrors primary (R7).
    p_sec_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trim_sec == -trim_pri);

    // Disabled means zero trim (R2).
    p_zero_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_en |-> trim_pri == '0);

    // Enabled means full-magnitude trim of either sign (R3).
    p_fixed_mag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trim_en |-> (trim_pri == MAG_POS || trim_pri == MAG_NEG));

    // Nothing moves without a strobe (R8).
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> ($stable(trim_pri) && $stable(trim_en)));
endmodule

bind npb_trim_ctrl npb_trim_ctrl_chk #(
    .VOLT_W(VOLT_W), .TRIM_W(TRIM_W), .TRIM_MAG(TRIM_MAG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_vld (sample_vld),
    .trim_pri   (trim_pri),
    .trim_sec   (trim_sec),
    .trim_en    (trim_en)
);

// File: tb/npb_trim_ctrl_test.sv
module npb_trim_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int VOLT_W     = 16;
    localparam int TRIM_W     = 12;
    localparam int TRIM_MAG   = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_vld = 1'b0;
    logic signed [VOLT_W-1:0] cap_volt = '0;
    logic signed [VOLT_W-1:0] bus_volt = '0;
    logic [VOLT_W-1:0] dz_thr = 16'd10;
    logic [VOLT_W-1:0] hys_thr = 16'd100;
    logic signed [TRIM_W-1:0] trim_pri;
    logic signed [TRIM_W-1:0] trim_sec;
    logic trim_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_neg = 1'b0;
    bit m_arm = 1'b1;
    bit m_en = 1'b0;
    int m_trim = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npb_trim_ctrl #(.VOLT_W(VOLT_W), .TRIM_W(TRIM_W), .TRIM_MAG(TRIM_MAG)) uut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .cap_volt(cap_volt), .bus_volt(bus_volt),
        .dz_thr(dz_thr), .hys_thr(hys_thr),
        .trim_pri(trim_pri), .trim_sec(trim_sec), .trim_en(trim_en)
    );

    function automatic int half_floor(int b);
        if (b >= 0) return b / 2;
        return -((-b + 1) / 2);
    endfunction

    // Compare outputs with model; tag names the requirement under test.
    task automatic check(string tag);
        int act_p = int'(trim_pri);
        int act_s = int'(trim_sec);
        n_vec++;
        if (trim_en !== m_en || act_p != m_trim || act_s != -m_trim) begin
            n_bad++;
            $display("FAIL %s: en=%0b pri=%0d sec=%0d expected en=%0b pri=%0d sec=%0d",
                     tag, trim_en, act_p, act_s, m_en, m_trim, -m_trim);
        end
    endtask

    // Called at a negedge: drive, advance model, wait one cycle, compare.
    task automatic step(int cap, int bus, bit vld, string tag);
        int err, mag;
        bit a_dz, a_hy;
        cap_volt = VOLT_W'(cap);
        bus_volt = VOLT_W'(bus);
        sample_vld = vld;
        if (vld) begin
            err  = cap - half_floor(bus);
            mag  = (err < 0) ? -err : err;
            a_dz = mag > int'(dz_thr);
            a_hy = mag > int'(hys_thr);
            if (a_dz && a_hy && m_arm) m_neg = !m_neg;
            m_arm = !a_hy;
            m_en  = a_dz;
            m_trim = !a_dz ? 0 : (m_neg ? -TRIM_MAG : TRIM_MAG);
        end
        @(negedge clk);
        sample_vld = 1'b0;
        check(tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stimulus
        int mid;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5: reset state
        check("R5 reset");

        // R2 R3 R4 R6 R7: ramps through both bands, both directions, several steps
        mid = 2000;
        for (int s = 1; s <= 3; s++) begin
            for (int e = 0; e <= 150; e += s) step(mid + e, 4000, 1'b1, "R2 R3 R4 ramp up");
            for (int e = 150; e >= -150; e -= s) step(mid + e, 4000, 1'b1, "R4 R6 ramp down");
            for (int e = -150; e <= 0; e += s) step(mid + e, 4000, 1'b1, "R6 R7 ramp back");
        end

        // R2 boundary: exactly hd and hd+1 on both sides
        step(2010, 4000, 1'b1, "R2 at hd");
        step(2011, 4000, 1'b1, "R2 above hd");
        step(1990, 4000, 1'b1, "R2 at -hd");
        step(1989, 4000, 1'b1, "R2 below -hd");
        // R4 boundary: exactly H (no flip) then H+1 (flip) then stay out (no flip)
        step(2100, 4000, 1'b1, "R4 at H");
        step(2101, 4000, 1'b1, "R4 past H");
        step(2130, 4000, 1'b1, "R4 stay out");
        step(2100, 4000, 1'b1, "R4 rearm");
        step(2101, 4000, 1'b1, "R4 second flip");

        // R1: odd bus values round toward minus infinity
        step(2010, 4001, 1'b1, "R1 odd bus edge");
        step(2011, 4001, 1'b1, "R1 odd bus over");
        step(-1991, -4001, 1'b1, "R1 negative bus edge");
        step(-1990, -4001, 1'b1, "R1 negative bus over");
        step(-2012, -4001, 1'b1, "R1 negative bus below");

        // R8: inputs move without strobe; outputs must hold
        step(2050, 4000, 1'b1, "R8 setup");
        for (int i = 0; i < 40; i++)
            step(int'($urandom_range(0, 4000)), int'($urandom_range(0, 8000)), 1'b0, "R8 hold");

        // R9: thresholds changed at run time
        dz_thr = 16'd50;
        step(2040, 4000, 1'b1, "R9 wider dead band");
        dz_thr = 16'd0;
        step(2001, 4000, 1'b1, "R9 zero dead band");
        step(2000, 4000, 1'b1, "R9 zero error");
        hys_thr = 16'd20;
        step(2025, 4000, 1'b1, "R9 narrow hysteresis");

        // R1..R7: random walk with sparse strobes and varying thresholds
        for (int blk = 0; blk < 8; blk++) begin
            int c = 2000;
            dz_thr  = VOLT_W'($urandom_range(0, 30));
            hys_thr = VOLT_W'($urandom_range(0, 120));
            for (int i = 0; i < 1500; i++) begin
                c += int'($urandom_range(0, 20)) - 10;
                if (c > 2300) c = 2300;
                if (c < 1700) c = 1700;
                step(c, 4000 + int'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0),
                     "R3 R4 R6 random walk");
            end
        end

        // R5: reset mid-run restores positive polarity and zero outputs
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_neg = 1'b0; m_arm = 1'b1; m_en = 1'b0; m_trim = 0;
        check("R5 reset again");
        dz_thr = 16'd10; hys_thr = 16'd100;
        step(2050, 4000, 1'b1, "R5 positive after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule